// File: doc/BRIEF.md
# Page-One Stack and Reset Sequencer

This block is the stack-pointer unit and reset sequencer of a small 8-bit processor core. It owns an 8-bit stack pointer. Every stack access goes to a fixed 256-byte page of a 16-bit address space, one byte wide. A push stores its byte first and then moves the pointer down. A pull moves the pointer up first and then reads. Both directions wrap silently inside the page. A transfer-load command copies an 8-bit register value into the pointer. Reset leaves the pointer undefined, so software has to load it before it uses the stack.

When reset is released, the block reads a two-byte start address from the top of memory, with the low byte first. It joins the two bytes and presents them as the program counter. Only after that does it raise `ready` and begin to accept stack commands. Reset also sets the interrupt-disable flag. The flag can be changed only once the core is running.

The unit shares one memory port between the vector fetch and stack traffic. Memory reads are combinational: the byte addressed in a cycle comes back in that same cycle.

Top module: `stk_reset_unit`

## Requirements
- R1: Every stack write or read issued after the vector fetch uses address 0x0100 plus the 8-bit pointer, so it lies within 0x0100..0x01FF.
- R2: A push drives `mem_we` high in the cycle it is accepted and writes its byte at 0x0100 plus the current pointer. The pointer then decreases by one, so the next push lands one address lower.
- R3: Pointer arithmetic wraps modulo 256 with no indication. A push at pointer 0x00 writes 0x0100 and the next push writes 0x01FF. A pull at pointer 0xFF reads 0x0100.
- R4: A pull increments the pointer and reads 0x0100 plus the new value in the same cycle, with `mem_re` high. The byte read appears on `pull_data`, with `pull_valid` high for exactly one cycle, one cycle later.
- R5: A transfer-load sets the pointer to `xfer_val`. The next push then writes 0x0100 plus that value.
- R6: After reset is released, the block reads 0xFFFC and then 0xFFFD. It loads `pc` with {byte at 0xFFFD, byte at 0xFFFC} and only then raises `ready`.
- R7: `irq_mask` is 1 while reset is asserted and throughout the vector fetch. Once `ready` is high, `irq_clr` drives it to 0 and `irq_set` drives it to 1 one cycle later; set wins if both are given. Before `ready`, both inputs are ignored.
- R8: Push, pull, load and mask requests made before `ready` first rises are ignored: `mem_we` stays 0 and nothing reaches the stack.
- R9: Reset asserted during the vector fetch aborts it. After the new release, the fetch restarts at 0xFFFC and `irq_mask` stays 1.
- R10: A load and a push in the same cycle perform the load first, with no write in that cycle. The push follows in the next cycle at the new pointer while `ready` is 0, and requests given in that cycle are ignored.
- R11: A push and a pull in the same cycle perform only the push. A pull given with a load is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| push_req | input | 1 | Push `push_val` onto the stack |
| push_val | input | 8 | Byte to push |
| pull_req | input | 1 | Pull one byte from the stack |
| xfer_req | input | 1 | Load the pointer from `xfer_val` |
| xfer_val | input | 8 | New pointer value |
| irq_set | input | 1 | Set the interrupt-disable flag |
| irq_clr | input | 1 | Clear the interrupt-disable flag |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| pull_data | output | 8 | Byte returned by a pull |
| pull_valid | output | 1 | One-cycle strobe for `pull_data` |
| pc | output | 16 | Program counter loaded from the reset vector |
| irq_mask | output | 1 | Interrupt-disable flag |
| ready | output | 1 | Unit accepts commands |

## Verification
The bench exercises both wrap directions at the page edge. A design that carried into the page byte would write to 0x0200 or 0x00FF. One that decremented before writing would shift every stacked byte by one address, and pulls would return the wrong bytes. The bench holds stack and mask requests high through the boot fetch, so an early write or an early mask change shows up at once. It aborts a fetch halfway and checks that the restart reads 0xFFFC again instead of resuming at 0xFFFD. It also issues a load together with a push, which exposes a design that writes at the old pointer or drops the push.

// File: rtl/stk_pkg.sv
package stk_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_LO   = 2'd1,
    SEQ_HI   = 2'd2,
    SEQ_RUN  = 2'd3
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_PUSH = 2'd1,
    OP_PULL = 2'd2
  } stk_op_t;

endpackage

// File: rtl/stk_rst_sync.sv
module stk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] shift_q;
  logic [STAGES-1:0] shift_d;

  always_comb begin
    shift_d = {shift_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shift_q <= '0;
    else        shift_q <= shift_d;
  end

  assign rst_n_sync = shift_q[STAGES-1];

endmodule

// File: rtl/stk_vector_seq.sv
module stk_vector_seq
  import stk_pkg::*;
#(
  parameter int              ADDR_W   = 16,
  parameter int              DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_ADDR = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] rd_data,
  output logic              fetch_re,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] pc,
  output logic              seq_done
);

  localparam logic [ADDR_W-1:0] VEC_HI = VEC_ADDR + ADDR_W'(1);

  seq_state_t        state_q, state_d;
  logic [DATA_W-1:0] lo_q;
  logic              lo_en;
  logic [ADDR_W-1:0] pc_q;
  logic              pc_en;

  always_comb begin
    state_d    = state_q;
    fetch_re   = 1'b0;
    fetch_addr = VEC_ADDR;
    lo_en      = 1'b0;
    pc_en      = 1'b0;
    unique case (state_q)
      SEQ_IDLE: state_d = SEQ_LO;
      SEQ_LO: begin
        fetch_re = 1'b1;
        lo_en    = 1'b1;
        state_d  = SEQ_HI;
      end
      SEQ_HI: begin
        fetch_re   = 1'b1;
        fetch_addr = VEC_HI;
        pc_en      = 1'b1;
        state_d    = SEQ_RUN;
      end
      SEQ_RUN: state_d = SEQ_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk) begin
    if (lo_en) lo_q <= rd_data;
    if (pc_en) pc_q <= ADDR_W'({rd_data, lo_q});
  end

  assign pc       = pc_q;
  assign seq_done = (state_q == SEQ_RUN);

  // R6: the high byte is always fetched right after the low byte
  p_hi_after_lo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_HI) |-> ($past(state_q) == SEQ_LO));

  // R9: a fetch always begins from the idle state, never mid-way
  p_lo_after_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_LO) |-> ($past(state_q) == SEQ_IDLE));

  // R6: once running, the sequencer stays done until reset
  p_done_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> seq_done);

  // R6: pc holds once loaded
  p_pc_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && $past(seq_done)) |-> $stable(pc));

endmodule

// File: rtl/stk_pointer.sv
module stk_pointer
  import stk_pkg::*;
#(
  parameter int                       ADDR_W     = 16,
  parameter int                       DATA_W     = 8,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE = 'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_val,
  input  logic              pull_req,
  input  logic              xfer_req,
  input  logic [DATA_W-1:0] xfer_val,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_we,
  output logic              acc_re,
  output logic [DATA_W-1:0] acc_wdata,
  output logic [DATA_W-1:0] pull_data,
  output logic              pull_valid,
  output logic              busy
);

  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  logic [DATA_W-1:0] sp_q, sp_d;
  logic              sp_en;
  logic              pend_q, pend_d;
  logic [DATA_W-1:0] pend_val_q;
  logic              pend_val_en;
  logic              pv_q, pv_d;
  logic [DATA_W-1:0] pdata_q;
  logic              pdata_en;
  logic [DATA_W-1:0] sp_inc;
  logic [DATA_W-1:0] wr_byte;
  stk_op_t           op;

  assign sp_inc = sp_q + ONE;

  // command arbitration: deferred push, then load, then push, then pull
  always_comb begin
    op          = OP_NONE;
    sp_d        = sp_q;
    sp_en       = 1'b0;
    pend_d      = 1'b0;
    pend_val_en = 1'b0;
    wr_byte     = push_val;
    if (pend_q) begin
      op      = OP_PUSH;
      wr_byte = pend_val_q;
    end else if (en) begin
      if (xfer_req) begin
        sp_d        = xfer_val;
        sp_en       = 1'b1;
        pend_d      = push_req;
        pend_val_en = push_req;
      end else if (push_req) begin
        op = OP_PUSH;
      end else if (pull_req) begin
        op = OP_PULL;
      end
    end
    if (op == OP_PUSH) begin
      sp_d  = sp_q - ONE;
      sp_en = 1'b1;
    end else if (op == OP_PULL) begin
      sp_d  = sp_inc;
      sp_en = 1'b1;
    end
  end

  always_comb begin
    acc_we    = (op == OP_PUSH);
    acc_re    = (op == OP_PULL);
    acc_wdata = wr_byte;
    acc_addr  = (op == OP_PULL) ? {STACK_PAGE, sp_inc} : {STACK_PAGE, sp_q};
    pv_d      = (op == OP_PULL);
    pdata_en  = (op == OP_PULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      pv_q   <= 1'b0;
    end else begin
      pend_q <= pend_d;
      pv_q   <= pv_d;
    end
  end

  // datapath registers carry no reset: the pointer is undefined after reset
  always_ff @(posedge clk) begin
    if (sp_en)       sp_q       <= sp_d;
    if (pend_val_en) pend_val_q <= push_val;
    if (pdata_en)    pdata_q    <= rd_data;
  end

  assign pull_data  = pdata_q;
  assign pull_valid = pv_q;
  assign busy       = pend_q;

  // R2: every write is followed by a pointer one lower
  p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_we |=> (sp_q == DATA_W'($past(sp_q) - ONE)));

  // R5: an accepted load puts xfer_val in the pointer
  p_xfer_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && xfer_req && !pend_q) |=> (sp_q == $past(xfer_val)));

  // R10: a deferred push writes in the following cycle
  p_defer_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && xfer_req && push_req && !pend_q) |=> acc_we);

  // R4: the pull strobe only follows a read access
  p_pull_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pull_valid |-> $past(acc_re));

  // R11: never a read and a write in one cycle
  p_single_access_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_we, acc_re}));

endmodule

// File: rtl/stk_reset_unit.sv
module stk_reset_unit
  import stk_pkg::*;
#(
  parameter int                       ADDR_W      = 16,
  parameter int                       DATA_W      = 8,
  parameter int                       SYNC_STAGES = 2,
  parameter logic [ADDR_W-DATA_W-1:0] STACK_PAGE  = 'h01,
  parameter logic [ADDR_W-1:0]        VEC_ADDR    = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_req,
  input  logic [DATA_W-1:0] push_val,
  input  logic              pull_req,
  input  logic              xfer_req,
  input  logic [DATA_W-1:0] xfer_val,
  input  logic              irq_set,
  input  logic              irq_clr,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] pull_data,
  output logic              pull_valid,
  output logic [ADDR_W-1:0] pc,
  output logic              irq_mask,
  output logic              ready
);

  logic              rst_int_n;
  logic              fetch_re;
  logic [ADDR_W-1:0] fetch_addr;
  logic              seq_done;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_we, acc_re;
  logic [DATA_W-1:0] acc_wdata;
  logic              stk_busy;
  logic              mask_q, mask_d, mask_en;

  stk_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_int_n)
  );

  stk_vector_seq #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .VEC_ADDR (VEC_ADDR)
  ) i_vector_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .rd_data    (mem_rdata),
    .fetch_re   (fetch_re),
    .fetch_addr (fetch_addr),
    .pc         (pc),
    .seq_done   (seq_done)
  );

  stk_pointer #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE)
  ) i_pointer (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (seq_done),
    .push_req   (push_req),
    .push_val   (push_val),
    .pull_req   (pull_req),
    .xfer_req   (xfer_req),
    .xfer_val   (xfer_val),
    .rd_data    (mem_rdata),
    .acc_addr   (acc_addr),
    .acc_we     (acc_we),
    .acc_re     (acc_re),
    .acc_wdata  (acc_wdata),
    .pull_data  (pull_data),
    .pull_valid (pull_valid),
    .busy       (stk_busy)
  );

  // shared memory port: vector fetch owns it until the sequence completes
  always_comb begin
    if (seq_done) begin
      mem_addr = acc_addr;
      mem_we   = acc_we;
      mem_re   = acc_re;
    end else begin
      mem_addr = fetch_addr;
      mem_we   = 1'b0;
      mem_re   = fetch_re;
    end
    mem_wdata = acc_wdata;
  end

  assign ready = seq_done && !stk_busy;

  // interrupt-disable flag; set has priority over clear
  always_comb begin
    mask_en = ready && (irq_set || irq_clr);
    mask_d  = irq_set;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)   mask_q <= 1'b1;
    else if (mask_en) mask_q <= mask_d;
  end

  assign irq_mask = mask_q;

  // R1: stack traffic stays inside the stack page
  p_stack_page_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seq_done && (mem_we || mem_re)) |-> (mem_addr[ADDR_W-1:DATA_W] == STACK_PAGE));

  // R8: no write reaches memory before the vector fetch completes
  p_no_early_write_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    !seq_done |-> !mem_we);

  // R7: interrupts stay disabled through the boot fetch
  p_mask_boot_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !seq_done |-> irq_mask);

  // R7: the flag only moves while the unit is ready
  p_mask_gated_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    !$past(ready) |-> $stable(irq_mask));

  // R10: ready drops for exactly the deferred-push cycle
  p_ready_gap_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    (seq_done && !ready) |=> ready);

endmodule

// File: tb/test_stk_reset_unit.sv
`timescale 1ns/1ps
module test_stk_reset_unit;

  logic        clk;
  logic        rst_n;
  logic        push_req, pull_req, xfer_req, irq_set, irq_clr;
  logic [7:0]  push_val, xfer_val;
  logic [15:0] mem_addr;
  logic        mem_we, mem_re;
  logic [7:0]  mem_wdata, mem_rdata;
  logic [7:0]  pull_data;
  logic        pull_valid;
  logic [15:0] pc;
  logic        irq_mask, ready;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0] stk [256];
  logic [7:0] vec_lo, vec_hi;

  stk_reset_unit i_stk_reset_unit (
    .clk(clk), .rst_n(rst_n),
    .push_req(push_req), .push_val(push_val),
    .pull_req(pull_req), .xfer_req(xfer_req), .xfer_val(xfer_val),
    .irq_set(irq_set), .irq_clr(irq_clr),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .pull_data(pull_data), .pull_valid(pull_valid),
    .pc(pc), .irq_mask(irq_mask), .ready(ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // memory model: combinational read, write on the clock edge
  always_comb begin
    if (mem_addr == 16'hFFFC)         mem_rdata = vec_lo;
    else if (mem_addr == 16'hFFFD)    mem_rdata = vec_hi;
    else if (mem_addr[15:8] == 8'h01) mem_rdata = stk[mem_addr[7:0]];
    else                              mem_rdata = 8'hEE;
  end

  always_ff @(posedge clk) begin
    if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle_inputs;
    push_req = 0; pull_req = 0; xfer_req = 0; irq_set = 0; irq_clr = 0;
  endtask

  // waits for ready, tracking the fetch order; inputs left as the caller set them
  task automatic boot(input logic [15:0] exp_pc, input bit hold_reqs);
    logic [15:0] prev_rd;
    bit          saw_hi, order_ok, early_we, mask_ok;
    prev_rd  = 16'h0000;
    saw_hi   = 0; order_ok = 0; early_we = 0; mask_ok = 1;
    if (hold_reqs) begin
      push_req = 1; push_val = 8'hAA; pull_req = 1;
      xfer_req = 1; xfer_val = 8'h10; irq_clr = 1;
    end
    for (int i = 0; i < 12 && !ready; i++) begin
      step();
      if (!ready) begin
        if (mem_we) early_we = 1;
        if (!irq_mask) mask_ok = 0;
        if (mem_re && mem_addr == 16'hFFFD && !saw_hi) begin
          saw_hi   = 1;
          order_ok = (prev_rd == 16'hFFFC);
        end
        if (mem_re) prev_rd = mem_addr;
      end
    end
    idle_inputs();
    chk("R6", "ready after fetch", 32'(ready), 32'd1);
    chk("R6", "low byte read before 0xFFFD", 32'(order_ok), 32'd1);
    chk("R6", "pc from vector", 32'(pc), 32'(exp_pc));
    chk("R7", "mask set during boot and at ready", 32'(mask_ok && irq_mask), 32'd1);
    if (hold_reqs)
      chk("R8", "no write before ready", 32'(early_we), 32'd0);
  endtask

  // op: 0 load, 1 push, 2 pull
  task automatic apply_op(input logic [1:0] op, input logic [7:0] val,
                          input logic [15:0] eaddr, input logic [7:0] edata);
    idle_inputs();
    if (op == 2'd0) begin xfer_req = 1; xfer_val = val; end
    if (op == 2'd1) begin push_req = 1; push_val = val; end
    if (op == 2'd2) pull_req = 1;
    #1;
    if (op == 2'd1) begin
      chk("R2", "push write strobe", 32'(mem_we), 32'd1);
      chk("R1", "push address", 32'(mem_addr), 32'(eaddr));
      chk("R2", "push data", 32'(mem_wdata), 32'(val));
    end
    if (op == 2'd2) begin
      chk("R4", "pull read strobe", 32'(mem_re), 32'd1);
      chk("R1", "pull address", 32'(mem_addr), 32'(eaddr));
    end
    step();
    idle_inputs();
    if (op == 2'd2) begin
      chk("R4", "pull strobe", 32'(pull_valid), 32'd1);
      chk("R4", "pull data", 32'(pull_data), 32'(edata));
    end
  endtask

  // {op, value, expected address, expected pulled byte}
  localparam logic [33:0] VEC [13] = '{
    {2'd0, 8'hFF, 16'h0000, 8'h00},  // R5 load FF
    {2'd1, 8'h11, 16'h01FF, 8'h00},  // R2
    {2'd1, 8'h22, 16'h01FE, 8'h00},  // R2 one lower
    {2'd2, 8'h00, 16'h01FE, 8'h22},  // R4
    {2'd2, 8'h00, 16'h01FF, 8'h11},  // R4
    {2'd0, 8'h01, 16'h0000, 8'h00},  // R5 load 01
    {2'd1, 8'h33, 16'h0101, 8'h00},
    {2'd1, 8'h44, 16'h0100, 8'h00},  // R3 pointer goes 00 -> FF
    {2'd1, 8'h55, 16'h01FF, 8'h00},  // R3 wrapped
    {2'd2, 8'h00, 16'h01FF, 8'h55},
    {2'd2, 8'h00, 16'h0100, 8'h44},  // R3 FF -> 00 upward
    {2'd2, 8'h00, 16'h0101, 8'h33},
    {2'd0, 8'hFF, 16'h0000, 8'h00}
  };

  initial begin
    for (int i = 0; i < 256; i++) stk[i] = 8'h00;
    vec_lo = 8'h34; vec_hi = 8'hC2;
    idle_inputs();
    push_val = 0; xfer_val = 0;
    rst_n = 0;
    repeat (3) step();
    chk("R7", "mask in reset", 32'(irq_mask), 32'd1);
    chk("R6", "not ready in reset", 32'(ready), 32'd0);
    chk("R8", "no write in reset", 32'(mem_we), 32'd0);
    rst_n = 1;
    boot(16'hC234, 1);
    chk("R8", "stack untouched by early push", 32'(stk[8'h10]), 32'h00);

    foreach (VEC[i]) apply_op(VEC[i][33:32], VEC[i][31:24], VEC[i][23:8], VEC[i][7:0]);
    // last row loaded FF: pull wraps to 0x0100
    apply_op(2'd2, 8'h00, 16'h0100, 8'h44);  // R3

    // R10: load and push together
    apply_op(2'd0, 8'hFF, 16'h0000, 8'h00);
    idle_inputs();
    xfer_req = 1; xfer_val = 8'h80; push_req = 1; push_val = 8'h66;
    #1;
    chk("R10", "no write in load cycle", 32'(mem_we), 32'd0);
    step();
    idle_inputs();
    pull_req = 1;  // must be ignored in the deferred cycle
    #1;
    chk("R10", "ready low while push deferred", 32'(ready), 32'd0);
    chk("R10", "deferred push write", 32'(mem_we), 32'd1);
    chk("R10", "deferred push address", 32'(mem_addr), 32'h0180);
    chk("R10", "deferred push data", 32'(mem_wdata), 32'h66);
    step();
    idle_inputs();
    chk("R10", "ready back", 32'(ready), 32'd1);
    chk("R10", "pull in deferred cycle ignored", 32'(pull_valid), 32'd0);
    apply_op(2'd1, 8'h77, 16'h017F, 8'h00);

    // R11: push and pull together -> push only
    push_req = 1; push_val = 8'h99; pull_req = 1;
    #1;
    chk("R11", "push wins write", 32'(mem_we), 32'd1);
    chk("R11", "push wins no read", 32'(mem_re), 32'd0);
    chk("R11", "push wins address", 32'(mem_addr), 32'h017E);
    step();
    idle_inputs();
    chk("R11", "no pull strobe", 32'(pull_valid), 32'd0);
    // R11: pull together with load is dropped, pointer loaded
    xfer_req = 1; xfer_val = 8'h40; pull_req = 1;
    #1;
    chk("R11", "no read with load", 32'(mem_re), 32'd0);
    step();
    idle_inputs();
    chk("R11", "no pull strobe after load", 32'(pull_valid), 32'd0);
    apply_op(2'd1, 8'h12, 16'h0140, 8'h00);  // R5

    // R7: mask control when ready
    irq_clr = 1;
    step();
    idle_inputs();
    chk("R7", "mask cleared", 32'(irq_mask), 32'd0);
    irq_set = 1; irq_clr = 1;
    step();
    idle_inputs();
    chk("R7", "set wins", 32'(irq_mask), 32'd1);
    irq_clr = 1;
    step();
    idle_inputs();
    chk("R7", "mask cleared again", 32'(irq_mask), 32'd0);

    // R9: reset sets mask at once, then abort a fetch halfway
    rst_n = 0;
    #1;
    chk("R9", "reset sets mask", 32'(irq_mask), 32'd1);
    chk("R9", "reset drops ready", 32'(ready), 32'd0);
    step();
    vec_lo = 8'h78; vec_hi = 8'h9A;
    rst_n = 1;
    for (int i = 0; i < 12 && !(mem_re && mem_addr == 16'hFFFD); i++) step();
    chk("R9", "reached high byte fetch", 32'(mem_addr), 32'hFFFD);
    rst_n = 0;
    step();
    chk("R9", "mask held across abort", 32'(irq_mask), 32'd1);
    rst_n = 1;
    boot(16'h9A78, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule